// File: doc/BRIEF.md
# RTC Host Register Bank with Interrupt

This block is the host-visible register file of a PC-style real-time clock. It stores a 128-byte bank. The low fourteen bytes hold the time and alarm fields, the calendar bytes and four control/status bytes. The rest of the bank is plain storage, a century byte and one control byte, and every bit of it is read/write. The host reaches the bank through a simple port with an address, write data, read and write strobes and a registered read-data output. A host-access block input freezes that port.

The timekeeping logic reports three kinds of events as single-cycle pulses: periodic, alarm and update-ended. The block latches each pulse into its status register (index 0Ch), and that register clears when the host reads it. Each flag has an enable bit. When a flag is set together with its enable, an internal active-high interrupt is raised. This interrupt goes out through a route-select field. When the field selects line 8, a polarity bit may invert the output.

Top module: `rtc_regbank`

## Requirements
- R1: A synchronous active-low reset forces bytes 00h to 0Dh to 00h, clears all status flags and sets `host_rdata_o` to 00h.
- R2: Bytes 00h to 09h (time, alarm and calendar fields) store every bit written by the host.
- R3: Bytes 0Eh to 7Fh store every bit written by the host. This includes the century byte at 7Dh and the control byte at 7Eh.
- R4: While `host_blk_i` is high, host writes change no byte. Host reads leave `host_rdata_o` unchanged and do not clear any status flag.
- R5: Byte 0Ch is read-only, and a host write to it has no effect.
- R6: Bit 7 of 0Ah, bit 0 of 0Bh and bit 7 of 0Dh are read-only and keep their reset value 0. The other bits of these bytes are written normally. Read-back masks are 7Fh, FEh and 7Fh.
- R7: An event pulse sets a status flag on the next edge. `tk_evt_i[2]` (periodic) sets 0Ch bit 6, `[1]` (alarm) sets bit 5 and `[0]` (update-ended) sets bit 4. Bits 3:0 of 0Ch read 0, and bit 7 reads as the OR of each flag ANDed with its enable in 0Bh bits 6:4.
- R8: An unblocked read of 0Ch returns the flags pending before the read, then clears them. The interrupt drops on the following cycle.
- R9: An event arriving in the same cycle as a clearing read of 0Ch keeps its flag set after the read.
- R10: The internal interrupt is high exactly while some flag and its enable are both set. Clearing the enable bit drops it.
- R11: When `irq_route_i` is 0, `irq_o` is 0. When it is 8 and `irq_pol_low_i` is 1, `irq_o` is the inverted interrupt. For any other non-zero route, `irq_o` equals the interrupt.
- R12: Read data appears on `host_rdata_o` on the clock edge that samples `host_rd_i`. A write becomes visible to a read strobed in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_blk_i | input | 1 | Host-access block; high makes reads and writes void |
| host_addr_i | input | 7 | Byte address within the bank |
| host_wdata_i | input | 8 | Host write data |
| host_wr_i | input | 1 | Write strobe, one cycle per write |
| host_rd_i | input | 1 | Read strobe, one cycle per read |
| host_rdata_o | output | 8 | Registered read data |
| tk_evt_i | input | 3 | Event pulses: [2] periodic, [1] alarm, [0] update-ended |
| irq_route_i | input | 4 | Interrupt route select; 0 keeps the output inactive |
| irq_pol_low_i | input | 1 | Invert the output when route 8 is selected |
| irq_o | output | 1 | Routed interrupt output |

## Verification
A status event and a clearing read of 0Ch can land in the same clock cycle. The question is whether the read clears the new flag or only the flags that were already pending. The bench provokes this directly by pulsing the periodic event while it reads 0Ch with the update-ended flag pending. It expects that read to return 90h and the following read to return C0h. The random phase then issues events together with reads of every address, including 0Ch. A bench model applies the pre-edge read value, then the clear, then the new events, and every read and every `irq_o` sample is compared against that model.

// File: rtl/rtc_regbank_pkg.sv
// Package: shared constants and write-mask rule for the RTC register bank.
// Assumes an 8-bit data path and a 7-bit byte address.
package rtc_regbank_pkg;

    localparam int RB_ADDR_W     = 7;
    localparam int RB_DATA_W     = 8;
    localparam int RB_CORE_BYTES = 14;
    localparam int RB_NUM_FLAGS  = 3;
    localparam int RB_SEL_W      = 4;
    localparam int RB_LINE8_CODE = 8;

    localparam int IDX_CTL_A  = 10;
    localparam int IDX_CTL_B  = 11;
    localparam int IDX_STAT_C = 12;
    localparam int IDX_CTL_D  = 13;

    // Host-writable bits of a core byte, by index.
    function automatic logic [RB_DATA_W-1:0] host_wr_mask(input int idx);
        logic [RB_DATA_W-1:0] m;
        m = '1;
        if (idx == IDX_CTL_A || idx == IDX_CTL_D) m[RB_DATA_W-1] = 1'b0;
        if (idx == IDX_CTL_B)                     m[0] = 1'b0;
        if (idx == IDX_STAT_C)                    m = '0;
        return m;
    endfunction

endpackage

// File: rtl/rtc_host_qual.sv
// Module: rtc_host_qual
// Qualifies host strobes with the access-block input and splits them by
// address region (core bytes, status byte, general-purpose store).
// Assumes single-cycle strobes; purely combinational.
module rtc_host_qual #(
    parameter int ADDR_W     = rtc_regbank_pkg::RB_ADDR_W,
    parameter int CORE_BYTES = rtc_regbank_pkg::RB_CORE_BYTES,
    parameter int STAT_IDX   = rtc_regbank_pkg::IDX_STAT_C
) (
    input  logic              host_blk_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic              host_wr_i,
    input  logic              host_rd_i,
    output logic              wr_core_o,
    output logic              wr_gp_o,
    output logic              rd_en_o,
    output logic              rd_stat_o
);

    logic in_core;

    // Region decode and strobe qualification.
    always_comb begin
        in_core   = (host_addr_i < ADDR_W'(CORE_BYTES));
        wr_core_o = host_wr_i && !host_blk_i && in_core;
        wr_gp_o   = host_wr_i && !host_blk_i && !in_core;
        rd_en_o   = host_rd_i && !host_blk_i;
        rd_stat_o = rd_en_o && (host_addr_i == ADDR_W'(STAT_IDX));
    end

endmodule

// File: rtl/rtc_core_bytes.sv
// Module: rtc_core_bytes
// Holds the low core bytes (time, alarm, calendar, control). The status
// byte slot is not stored here and reads as zero. Read-only bits are
// protected with a per-byte write mask. Synchronous active-low reset
// clears every stored byte.
module rtc_core_bytes #(
    parameter int ADDR_W     = rtc_regbank_pkg::RB_ADDR_W,
    parameter int DATA_W     = rtc_regbank_pkg::RB_DATA_W,
    parameter int CORE_BYTES = rtc_regbank_pkg::RB_CORE_BYTES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [CORE_BYTES*DATA_W-1:0] core_flat_o
);

    import rtc_regbank_pkg::*;

    localparam int IDX_W = $clog2(CORE_BYTES);

    logic [DATA_W-1:0] bytes_q [CORE_BYTES];

    for (genvar i = 0; i < CORE_BYTES; i++) begin : g_byte
        if (i == IDX_STAT_C) begin : g_hole
            // Status byte lives in the status block; slot reads zero here.
            assign bytes_q[i] = '0;
        end else begin : g_store
            localparam logic [DATA_W-1:0] MASK = host_wr_mask(i);
            // Masked byte write with synchronous clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bytes_q[i] <= '0;
                else if (wr_i && addr_i == ADDR_W'(i))
                    bytes_q[i] <= (bytes_q[i] & ~MASK) | (wdata_i & MASK);
            end
        end
        assign core_flat_o[i*DATA_W +: DATA_W] = bytes_q[i];
    end

    // R6: a host write to control byte A leaves its top bit alone.
    a_r6_ro_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(IDX_CTL_A))
        |=> (bytes_q[IDX_CTL_A][DATA_W-1] == $past(bytes_q[IDX_CTL_A][DATA_W-1])));

    // R2: a time/calendar write lands whole in the addressed byte.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i < ADDR_W'(IDX_CTL_A))
        |=> (bytes_q[$past(addr_i[IDX_W-1:0])] == $past(wdata_i)));

endmodule

// File: rtl/rtc_gp_store.sv
// Module: rtc_gp_store
// General-purpose byte storage above the core bytes (includes century and
// control bytes). Not reset. Read is combinational on the address.
module rtc_gp_store #(
    parameter int ADDR_W = rtc_regbank_pkg::RB_ADDR_W,
    parameter int DATA_W = rtc_regbank_pkg::RB_DATA_W,
    parameter int BASE   = rtc_regbank_pkg::RB_CORE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rd_byte_o
);

    localparam int DEPTH = (1 << ADDR_W) - BASE;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] idx;

    // Offset of the address into the store.
    always_comb idx = addr_i - ADDR_W'(BASE);

    // Byte write into storage.
    always_ff @(posedge clk) begin
        if (wr_i && idx < ADDR_W'(DEPTH))
            mem_q[idx] <= wdata_i;
    end

    // Guarded read.
    always_comb rd_byte_o = (idx < ADDR_W'(DEPTH)) ? mem_q[idx] : '0;

    // R3: a stored byte reads back what was written.
    a_r3_gp_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mem_q[$past(idx)] == $past(wdata_i)));

endmodule

// File: rtl/rtc_stat_irq.sv
// Module: rtc_stat_irq
// Latches event pulses into status flags, clears them on a status read
// (events in the same cycle win), forms the internal interrupt from flags
// and enables, and routes it with optional inversion on line 8.
module rtc_stat_irq #(
    parameter int NUM_FLAGS  = rtc_regbank_pkg::RB_NUM_FLAGS,
    parameter int SEL_W      = rtc_regbank_pkg::RB_SEL_W,
    parameter int LINE8_CODE = rtc_regbank_pkg::RB_LINE8_CODE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] evt_i,
    input  logic                 clr_i,
    input  logic [NUM_FLAGS-1:0] en_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic                 pol_low_i,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 irq_int_o,
    output logic                 irq_o
);

    logic [NUM_FLAGS-1:0] flags_q;

    // Flag latch: clear on status read, set by events (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= (clr_i ? '0 : flags_q) | evt_i;
    end

    // Internal interrupt and routed output.
    always_comb begin
        irq_int_o = |(flags_q & en_i);
        if (sel_i == '0)
            irq_o = 1'b0;
        else if (sel_i == SEL_W'(LINE8_CODE) && pol_low_i)
            irq_o = !irq_int_o;
        else
            irq_o = irq_int_o;
    end

    assign flags_o = flags_q;

    // R8: a status read with no new event leaves no flag pending.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i == '0) |=> (flags_q == '0));

    // R9: every event flag is present after its pulse, read or not.
    a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/rtc_regbank.sv
// Module: rtc_regbank (top)
// Host-facing 128-byte register bank of a real-time clock with status
// flags and a routed interrupt. Read data is registered; a read of the
// status byte clears its flags on the same edge that captures them.
module rtc_regbank #(
    parameter int ADDR_W     = rtc_regbank_pkg::RB_ADDR_W,
    parameter int DATA_W     = rtc_regbank_pkg::RB_DATA_W,
    parameter int CORE_BYTES = rtc_regbank_pkg::RB_CORE_BYTES,
    parameter int NUM_FLAGS  = rtc_regbank_pkg::RB_NUM_FLAGS,
    parameter int SEL_W      = rtc_regbank_pkg::RB_SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_blk_i,
    input  logic [ADDR_W-1:0]    host_addr_i,
    input  logic [DATA_W-1:0]    host_wdata_i,
    input  logic                 host_wr_i,
    input  logic                 host_rd_i,
    output logic [DATA_W-1:0]    host_rdata_o,
    input  logic [NUM_FLAGS-1:0] tk_evt_i,
    input  logic [SEL_W-1:0]     irq_route_i,
    input  logic                 irq_pol_low_i,
    output logic                 irq_o
);

    import rtc_regbank_pkg::*;

    localparam int IDX_W    = $clog2(CORE_BYTES);
    localparam int FLAG_LSB = DATA_W - 1 - NUM_FLAGS;

    logic                         wr_core, wr_gp, rd_en, rd_stat;
    logic [CORE_BYTES*DATA_W-1:0] core_flat;
    logic [DATA_W-1:0]            gp_byte, core_byte, stat_byte, rd_value;
    logic [NUM_FLAGS-1:0]         flags, enables;
    logic                         irq_int;
    logic [DATA_W-1:0]            rdata_q;

    rtc_host_qual #(.ADDR_W(ADDR_W), .CORE_BYTES(CORE_BYTES), .STAT_IDX(IDX_STAT_C)) u_qual (
        .host_blk_i (host_blk_i),
        .host_addr_i(host_addr_i),
        .host_wr_i  (host_wr_i),
        .host_rd_i  (host_rd_i),
        .wr_core_o  (wr_core),
        .wr_gp_o    (wr_gp),
        .rd_en_o    (rd_en),
        .rd_stat_o  (rd_stat)
    );

    rtc_core_bytes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CORE_BYTES(CORE_BYTES)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_core),
        .addr_i     (host_addr_i),
        .wdata_i    (host_wdata_i),
        .core_flat_o(core_flat)
    );

    rtc_gp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(CORE_BYTES)) u_gp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_gp),
        .addr_i   (host_addr_i),
        .wdata_i  (host_wdata_i),
        .rd_byte_o(gp_byte)
    );

    rtc_stat_irq #(.NUM_FLAGS(NUM_FLAGS), .SEL_W(SEL_W), .LINE8_CODE(RB_LINE8_CODE)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (tk_evt_i),
        .clr_i    (rd_stat),
        .en_i     (enables),
        .sel_i    (irq_route_i),
        .pol_low_i(irq_pol_low_i),
        .flags_o  (flags),
        .irq_int_o(irq_int),
        .irq_o    (irq_o)
    );

    // Enable bits sit in control byte B at the same positions as the flags.
    assign enables = core_flat[IDX_CTL_B*DATA_W + FLAG_LSB +: NUM_FLAGS];

    // Read-value selection across regions.
    always_comb begin
        core_byte = core_flat[host_addr_i[IDX_W-1:0]*DATA_W +: DATA_W];
        stat_byte = {irq_int, flags, {FLAG_LSB{1'b0}}};
        if (host_addr_i == ADDR_W'(IDX_STAT_C))
            rd_value = stat_byte;
        else if (host_addr_i < ADDR_W'(CORE_BYTES))
            rd_value = core_byte;
        else
            rd_value = gp_byte;
    end

    // Read-data register, updated only on an unblocked read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_en)
            rdata_q <= rd_value;
    end

    assign host_rdata_o = rdata_q;

    // R4: a blocked cycle leaves the read data untouched.
    a_r4_blocked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        host_blk_i |=> $stable(host_rdata_o));

endmodule

// File: tb/rtc_regbank_tb.sv
module rtc_regbank_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_blk_i = 1'b0;
    logic [6:0] host_addr_i = '0;
    logic [7:0] host_wdata_i = '0;
    logic       host_wr_i = 1'b0;
    logic       host_rd_i = 1'b0;
    logic [7:0] host_rdata_o;
    logic [2:0] tk_evt_i = '0;
    logic [3:0] irq_route_i = 4'd1;
    logic       irq_pol_low_i = 1'b0;
    logic       irq_o;

    always #2 clk = ~clk;

    rtc_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .host_blk_i(host_blk_i),
        .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
        .host_wr_i(host_wr_i), .host_rd_i(host_rd_i), .host_rdata_o(host_rdata_o),
        .tk_evt_i(tk_evt_i), .irq_route_i(irq_route_i),
        .irq_pol_low_i(irq_pol_low_i), .irq_o(irq_o)
    );

    int total = 0;
    int fails = 0;

    logic [7:0] m_mem [128];
    logic [2:0] m_flags;
    logic [7:0] m_rdata;

    // Checks one value and reports a mismatch.
    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic m_irq_int();
        return |(m_flags & m_mem[11][6:4]);
    endfunction

    function automatic logic m_irq_out(logic [3:0] sel, logic pol);
        if (sel == 4'd0) return 1'b0;
        if (sel == 4'd8 && pol) return !m_irq_int();
        return m_irq_int();
    endfunction

    function automatic logic [7:0] m_read(logic [6:0] a);
        if (a == 7'h0C) return {m_irq_int(), m_flags, 4'b0};
        return m_mem[a];
    endfunction

    function automatic logic [7:0] m_mask(logic [6:0] a);
        case (a)
            7'h0A, 7'h0D: return 8'h7F;
            7'h0B:        return 8'hFE;
            7'h0C:        return 8'h00;
            default:      return 8'hFF;
        endcase
    endfunction

    // One host cycle: drive at negedge, check after the edge.
    task automatic op(bit rd, bit wr, bit blk, logic [6:0] a, logic [7:0] d,
                      logic [2:0] ev, string req);
        logic [7:0] exp_rd;
        @(negedge clk);
        host_rd_i = rd; host_wr_i = wr; host_blk_i = blk;
        host_addr_i = a; host_wdata_i = d; tk_evt_i = ev;
        exp_rd = m_read(a);
        @(negedge clk);
        host_rd_i = 1'b0; host_wr_i = 1'b0; host_blk_i = 1'b0; tk_evt_i = '0;
        if (rd && !blk) m_rdata = exp_rd;
        if (rd) chk(req, host_rdata_o, m_rdata);
        if (wr && !blk) m_mem[a] = (m_mem[a] & ~m_mask(a)) | (d & m_mask(a));
        if (rd && !blk && a == 7'h0C) m_flags = '0;
        m_flags = m_flags | ev;
        chk({req, " irq"}, {7'd0, irq_o}, {7'd0, m_irq_out(irq_route_i, irq_pol_low_i)});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 14; i++) m_mem[i] = 8'h00;
        m_flags = '0;
        m_rdata = 8'h00;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2417));
        for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
        do_reset();

        // R1: reset state.
        chk("R1 rdata after reset", host_rdata_o, 8'h00);
        for (int i = 0; i < 14; i++) op(1, 0, 0, 7'(i), 0, 0, "R1 core byte zero");

        // R3: fill the general-purpose region and read some back.
        for (int i = 14; i < 128; i++) op(0, 1, 0, 7'(i), 8'(i * 7 + 3), 0, "R3 fill");
        op(1, 0, 0, 7'h7D, 0, 0, "R3 century");
        op(1, 0, 0, 7'h7E, 0, 0, "R3 control");
        op(1, 0, 0, 7'h0E, 0, 0, "R3 low end");
        op(1, 0, 0, 7'h7F, 0, 0, "R3 top end");

        // R2: time, alarm and calendar bytes.
        for (int i = 0; i < 10; i++) op(0, 1, 0, 7'(i), 8'($urandom), 0, "R2 write");
        for (int i = 0; i < 10; i++) op(1, 0, 0, 7'(i), 0, 0, "R2 read");

        // R6: read-only bits.
        op(0, 1, 0, 7'h0A, 8'hFF, 0, "R6 wr A");
        op(0, 1, 0, 7'h0B, 8'hFF, 0, "R6 wr B");
        op(0, 1, 0, 7'h0D, 8'hFF, 0, "R6 wr D");
        op(1, 0, 0, 7'h0A, 0, 0, "R6 A reads 7F");
        chk("R6 A value", host_rdata_o, 8'h7F);
        op(1, 0, 0, 7'h0B, 0, 0, "R6 B reads FE");
        chk("R6 B value", host_rdata_o, 8'hFE);
        op(1, 0, 0, 7'h0D, 0, 0, "R6 D reads 7F");
        chk("R6 D value", host_rdata_o, 8'h7F);

        // R5: status byte ignores writes.
        op(0, 1, 0, 7'h0B, 8'h00, 0, "R5 disable");
        op(0, 1, 0, 7'h0C, 8'hFF, 0, "R5 wr C");
        op(1, 0, 0, 7'h0C, 0, 0, "R5 C still zero");
        chk("R5 C value", host_rdata_o, 8'h00);

        // R7, R8, R10: alarm flag, interrupt, clear on read.
        irq_route_i = 4'd1;
        op(0, 1, 0, 7'h0B, 8'h70, 0, "R10 enable");
        op(0, 0, 0, 0, 0, 3'b010, "R7 alarm event");
        chk("R10 irq high", {7'd0, irq_o}, 8'h01);
        op(1, 0, 0, 7'h0C, 0, 0, "R7 read C");
        chk("R7 C value", host_rdata_o, 8'hA0);
        chk("R8 irq dropped", {7'd0, irq_o}, 8'h00);
        op(1, 0, 0, 7'h0C, 0, 0, "R8 C cleared");
        chk("R8 C value", host_rdata_o, 8'h00);

        // R9: event in the same cycle as a clearing read.
        op(0, 0, 0, 0, 0, 3'b001, "R9 update event");
        op(1, 0, 0, 7'h0C, 0, 3'b100, "R9 read with event");
        chk("R9 read value", host_rdata_o, 8'h90);
        op(1, 0, 0, 7'h0C, 0, 0, "R9 kept flag");
        chk("R9 kept value", host_rdata_o, 8'hC0);

        // R10: clearing the enable drops the interrupt.
        op(0, 0, 0, 0, 0, 3'b010, "R10 alarm");
        op(0, 1, 0, 7'h0B, 8'h00, 0, "R10 disable");
        chk("R10 irq low", {7'd0, irq_o}, 8'h00);
        op(1, 0, 0, 7'h0C, 0, 0, "R10 C without bit7");
        chk("R10 C value", host_rdata_o, 8'h20);

        // R11: routing and polarity.
        irq_route_i = 4'd8; irq_pol_low_i = 1'b1;
        op(0, 0, 0, 0, 0, 0, "R11 line8 idle");
        chk("R11 line8 idle high", {7'd0, irq_o}, 8'h01);
        op(0, 1, 0, 7'h0B, 8'h40, 0, "R11 enable");
        op(0, 0, 0, 0, 0, 3'b100, "R11 line8 active low");
        chk("R11 line8 asserted", {7'd0, irq_o}, 8'h00);
        irq_route_i = 4'd0;
        op(0, 0, 0, 0, 0, 0, "R11 route zero");
        chk("R11 route zero value", {7'd0, irq_o}, 8'h00);
        irq_route_i = 4'd5;
        op(0, 0, 0, 0, 0, 0, "R11 other route");

        // R4: blocked access.
        op(0, 1, 1, 7'h20, 8'h5A, 0, "R4 blocked write");
        op(1, 0, 1, 7'h0C, 0, 0, "R4 blocked read C");
        op(1, 0, 0, 7'h20, 0, 0, "R4 byte unchanged");
        op(1, 0, 0, 7'h0C, 0, 0, "R4 flag survived");
        chk("R4 flag value", host_rdata_o, 8'hC0);

        // R12: data not present before the edge that samples the strobe.
        op(0, 1, 0, 7'h05, 8'h3C, 0, "R12 write");
        @(negedge clk);
        host_rd_i = 1'b1; host_addr_i = 7'h05;
        #1 chk("R12 before edge", host_rdata_o, m_rdata);
        @(negedge clk);
        host_rd_i = 1'b0;
        m_rdata = 8'h3C;
        chk("R12 after edge", host_rdata_o, 8'h3C);

        // R1: reset in mid-run.
        irq_route_i = 4'd1; irq_pol_low_i = 1'b0;
        op(0, 1, 0, 7'h0B, 8'h70, 0, "R1 pre");
        op(0, 0, 0, 0, 0, 3'b111, "R1 pre events");
        do_reset();
        chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);
        op(1, 0, 0, 7'h0C, 0, 0, "R1 C after reset");
        op(1, 0, 0, 7'h05, 0, 0, "R1 core after reset");

        // Random mix: R2 R3 R5 R7 R8 R9 R4 against the model.
        for (int n = 0; n < 600; n++) begin
            logic [6:0] a;
            logic [2:0] ev;
            bit rd, blk;
            a   = 7'($urandom_range(0, 127));
            if ($urandom_range(0, 2) == 0) a = 7'h0C;
            rd  = $urandom_range(0, 1) == 1;
            blk = $urandom_range(0, 7) == 0;
            ev  = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
            if ($urandom_range(0, 31) == 0) begin
                irq_route_i = 4'($urandom);
                irq_pol_low_i = 1'($urandom);
            end
            op(rd, !rd, blk, a, 8'($urandom), ev, "R8 random mix");
        end

        finish_run();
    end

endmodule